// File: doc/BRIEF.md
# Coin-Counting Coffee Dispenser Controller

This block is the control state machine for a coffee dispenser. A cup costs 15 cents. The coin sensor reports each accepted coin as a one-clock pulse on one of two inputs, one for a nickel (5 cents) and one for a dime (10 cents). Other coins never reach this block, and the machine gives no change. When the coins inserted since the last reset add up to 15 cents or more, the controller raises a release signal to the mechanism that dispenses the cup.

The controller is a Moore machine. It keeps a coin-history state in a 4-bit register, with one state for each distinct ordering of coins up to the point of payment: nine states in all. State minimization is deliberately not done. Four of the nine states hold credit below the price (0, 5, 10 by a nickel then a nickel, and 10 by a dime). The other five are paid states, and the release output is high in all of them. A paid state holds until the synchronous reset, whatever coins arrive. A nickel and a dime reported in the same clock are treated as a sensor fault, and both are ignored.

Top module: `coffee_vend_fsm`

## Requirements
- R1: When `rst` is high at a rising clock edge, the machine goes to the zero-credit state. From the following cycle, `dispense_open` is 0, and the next 15 cents of coins are needed before it rises again.
- R2: `dispense_open` is a function of the registered state only. It is 0 while the credit is below 15 cents and 1 in every paid state.
- R3: At zero credit, a nickel moves to 5 cents of credit and a dime moves to 10 cents, both with `dispense_open` still 0.
- R4: At 5 cents, a nickel moves to 10 cents (output stays 0), and a dime completes payment.
- R5: At 10 cents, whether reached by one dime or by two nickels, either coin completes payment. Overpayment by dime then dime reaches a paid state like any other sequence.
- R6: In a state below the price, a cycle with neither coin leaves the credit unchanged.
- R7: A cycle with both `nickel_in` and `dime_in` high leaves the credit unchanged, as if no coin had arrived.
- R8: Once `dispense_open` is 1, it stays 1 on every later cycle, whatever the coin inputs do, until `rst` is applied.
- R9: `dispense_open` rises exactly one clock after the edge that samples the completing coin, and never rises unless a coin was sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero credit |
| nickel_in | input | 1 | One-cycle pulse: a 5-cent coin was accepted |
| dime_in | input | 1 | One-cycle pulse: a 10-cent coin was accepted |
| dispense_open | output | 1 | High in every paid state; drives the release mechanism |

## Verification
The assertions assume that each coin pulse lasts exactly one clock and stands for exactly one coin. A pulse held high for several cycles would count as several coins. The assertions also take the simultaneous nickel-and-dime case as a legal input that the design must absorb without moving, so it is checked rather than excluded. The random stimulus changes the coin inputs only at the falling edge, holds each value for a single cycle, and draws the clash case on purpose alongside idle cycles and occasional resets. This exercises every coin ordering that reaches the price, including two dimes.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int STATE_W    = 4;
    localparam int PRICE_C    = 15;
    localparam int NICKEL_C   = 5;
    localparam int DIME_C     = 10;
    localparam int CREDIT_W   = 5;

    // Coin-history states; names spell the coins seen and the credit held.
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 4'd0,
        ST_N5     = 4'd1,
        ST_D10    = 4'd2,
        ST_NN10   = 4'd3,
        ST_ND15   = 4'd4,
        ST_DN15   = 4'd5,
        ST_DD20   = 4'd6,
        ST_NNN15  = 4'd7,
        ST_NND20  = 4'd8
    } vend_state_e;

    typedef enum logic [1:0] {
        COIN_NONE   = 2'd0,
        COIN_NICKEL = 2'd1,
        COIN_DIME   = 2'd2,
        COIN_CLASH  = 2'd3
    } coin_e;

    typedef struct packed {
        coin_e kind;
        logic  valid;   // exactly one usable coin this cycle
    } coin_evt_t;

    function automatic logic is_paid(vend_state_e s);
        return (s == ST_ND15) || (s == ST_DN15) || (s == ST_DD20) ||
               (s == ST_NNN15) || (s == ST_NND20);
    endfunction

    function automatic logic [CREDIT_W-1:0] credit_of(vend_state_e s);
        logic [CREDIT_W-1:0] c;
        case (s)
            ST_IDLE:                    c = CREDIT_W'(0);
            ST_N5:                      c = CREDIT_W'(NICKEL_C);
            ST_D10, ST_NN10:            c = CREDIT_W'(DIME_C);
            ST_ND15, ST_DN15, ST_NNN15: c = CREDIT_W'(PRICE_C);
            ST_DD20, ST_NND20:          c = CREDIT_W'(PRICE_C + NICKEL_C);
            default:                    c = '0;
        endcase
        return c;
    endfunction

    function automatic logic [CREDIT_W-1:0] coin_value(coin_e k);
        logic [CREDIT_W-1:0] v;
        case (k)
            COIN_NICKEL: v = CREDIT_W'(NICKEL_C);
            COIN_DIME:   v = CREDIT_W'(DIME_C);
            default:     v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/vend_coin_sense.sv
module vend_coin_sense
    import vend_pkg::*;
(
    input  logic      nickel_i,
    input  logic      dime_i,
    output coin_evt_t evt_o
);

    always_comb begin
        unique case ({dime_i, nickel_i})
            2'b01:   evt_o.kind = COIN_NICKEL;
            2'b10:   evt_o.kind = COIN_DIME;
            2'b11:   evt_o.kind = COIN_CLASH;
            default: evt_o.kind = COIN_NONE;
        endcase
        evt_o.valid = (evt_o.kind == COIN_NICKEL) || (evt_o.kind == COIN_DIME);
    end

endmodule

// File: rtl/vend_next_state.sv
module vend_next_state
    import vend_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  vend_state_e cur_i,
    input  coin_evt_t   evt_i,
    output vend_state_e nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        if (evt_i.valid) begin
            case (cur_i)
                ST_IDLE: nxt_o = (evt_i.kind == COIN_NICKEL) ? ST_N5   : ST_D10;
                ST_N5:   nxt_o = (evt_i.kind == COIN_NICKEL) ? ST_NN10 : ST_ND15;
                ST_D10:  nxt_o = (evt_i.kind == COIN_NICKEL) ? ST_DN15 : ST_DD20;
                ST_NN10: nxt_o = (evt_i.kind == COIN_NICKEL) ? ST_NNN15 : ST_NND20;
                default: nxt_o = cur_i;   // paid states hold
            endcase
        end
    end

    // R7: a clashing coin pair must not move the machine.
    p_clash_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (evt_i.kind == COIN_CLASH) |-> (nxt_o == cur_i));

    // R3, R4, R5: an unpaid state advances by exactly the coin's value.
    p_credit_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!is_paid(cur_i) && evt_i.valid) |->
        (credit_of(nxt_o) == credit_of(cur_i) + coin_value(evt_i.kind)));

    // R8: paid states never leave without reset.
    p_paid_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        is_paid(cur_i) |-> (nxt_o == cur_i));

endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
    import vend_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  vend_state_e nxt_i,
    output vend_state_e cur_o,
    output logic        open_o
);

    always_ff @(posedge clk) begin
        if (rst) cur_o <= ST_IDLE;
        else     cur_o <= nxt_i;
    end

    assign open_o = is_paid(cur_o);

    // R1: reset lands in zero credit.
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (cur_o == ST_IDLE));

    // R2: state stays within the nine legal codes.
    p_legal_state_r2: assert property (@(posedge clk) disable iff (rst)
        (cur_o <= ST_NND20));

endmodule

// File: rtl/coffee_vend_fsm.sv
module coffee_vend_fsm
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nickel_in,
    input  logic dime_in,
    output logic dispense_open
);

    coin_evt_t   coin_evt;
    vend_state_e state_cur;
    vend_state_e state_nxt;

    vend_coin_sense u_sense (
        .nickel_i (nickel_in),
        .dime_i   (dime_in),
        .evt_o    (coin_evt)
    );

    vend_next_state u_next (
        .clk   (clk),
        .rst   (rst),
        .cur_i (state_cur),
        .evt_i (coin_evt),
        .nxt_o (state_nxt)
    );

    vend_state_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .nxt_i  (state_nxt),
        .cur_o  (state_cur),
        .open_o (dispense_open)
    );

    // R1: output low in the cycle after a reset edge.
    p_reset_closed_r1: assert property (@(posedge clk)
        rst |=> !dispense_open);

    // R8: release latches until reset.
    p_open_latched_r8: assert property (@(posedge clk) disable iff (rst)
        dispense_open |=> dispense_open);

    // R6: no coin, no change at the output.
    p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!nickel_in && !dime_in) |=> $stable(dispense_open));

    // R9: a rise needs a single coin sampled at the preceding edge.
    p_rise_needs_coin_r9: assert property (@(posedge clk) disable iff (rst)
        (!dispense_open && (nickel_in == dime_in)) |=> !dispense_open);

endmodule

// File: tb/coffee_vend_fsm_bench.sv
`timescale 1ns/1ps
module coffee_vend_fsm_bench;

    logic clk = 1'b0;
    logic rst;
    logic nickel_in;
    logic dime_in;
    logic dispense_open;

    int checks   = 0;
    int failures = 0;
    int credit   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    coffee_vend_fsm u_coffee_vend_fsm (
        .clk           (clk),
        .rst           (rst),
        .nickel_in     (nickel_in),
        .dime_in       (dime_in),
        .dispense_open (dispense_open)
    );

    function automatic int model_next(int c, bit n, bit d);
        if (c >= 15) return c;
        if (n && d)  return c;
        if (n)       return c + 5;
        if (d)       return c + 10;
        return c;
    endfunction

    function automatic bit model_open(int c);
        return c >= 15;
    endfunction

    task automatic check(string req);
        bit exp;
        exp = model_open(credit);
        checks++;
        if (dispense_open !== exp) begin
            failures++;
            $display("FAIL %s: dispense_open=%0b expected=%0b (credit=%0d)",
                     req, dispense_open, exp, credit);
        end
    endtask

    // Drive at negedge, let one posedge act, check at the next negedge.
    task automatic step(bit r, bit n, bit d, string req);
        rst = r; nickel_in = n; dime_in = d;
        @(negedge clk);
        credit = r ? 0 : model_next(credit, n, d);
        check(req);
    endtask

    task automatic do_reset();
        step(1'b1, 1'b0, 1'b0, "R1");
    endtask

    initial begin
        rst = 1'b1; nickel_in = 1'b0; dime_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        credit = 0;
        check("R1");

        // R3/R4: nickel-nickel-nickel
        step(0,1,0,"R3"); step(0,1,0,"R4"); step(0,0,0,"R6");
        step(0,1,0,"R5"); step(0,0,1,"R8"); step(0,1,0,"R8");
        do_reset();
        // R4: nickel then dime
        step(0,1,0,"R3"); step(0,0,1,"R4"); step(0,0,0,"R8");
        do_reset();
        // R5: dime then nickel
        step(0,0,1,"R3"); step(0,1,0,"R5");
        do_reset();
        // R5: overpayment dime then dime
        step(0,0,1,"R3"); step(0,0,0,"R6"); step(0,0,1,"R5");
        step(0,1,1,"R8"); step(0,0,1,"R8");
        do_reset();
        // R5: nickel, nickel, dime
        step(0,1,0,"R3"); step(0,1,0,"R4"); step(0,0,1,"R5");
        do_reset();
        // R7: clash ignored at each unpaid credit
        step(0,1,1,"R7"); step(0,1,0,"R3"); step(0,1,1,"R7");
        step(0,1,0,"R4"); step(0,1,1,"R7"); step(0,0,0,"R6");
        step(0,1,0,"R5");
        // R1: reset mid-payment restarts full price
        do_reset(); step(0,0,1,"R3"); do_reset();
        step(0,1,0,"R1"); step(0,1,0,"R1"); step(0,1,0,"R9");

        // Random mix with fixed seed
        begin
            int unsigned seed_dummy;
            seed_dummy = $urandom(32'h5EED_C0FE);
        end
        for (int i = 0; i < 4000; i++) begin
            int unsigned pick;
            pick = $urandom_range(0, 99);
            if (pick < 4)       step(1,0,0,"R1");
            else if (pick < 34) step(0,0,0,"R6");
            else if (pick < 60) step(0,1,0,"R9");
            else if (pick < 86) step(0,0,1,"R9");
            else                step(0,1,1,"R7");
        end
        rst = 1'b0; nickel_in = 1'b0; dime_in = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule